// File: doc/BRIEF.md
# DMA Channel Interrupt Aggregator

This block gathers the per-channel event pulses of a multi-channel DMA engine into five separate event classes: transfer done, block done, source transaction, destination transaction and fault. Every class keeps one raw pending bit per channel and an enable (unmask) bit per channel. Software clears a pending bit by writing a one to it. The pending bits that are also enabled form the visible status of the class. One summary word has a bit per class that shows which classes have visible work. A single interrupt line is the OR of every visible bit.

The channel engines pulse an event input for one cycle when something happens. Software uses a flat register port that has a write strobe, an address and write data, and it reads data back combinationally. Each class has four register slots: raw, visible, enable and clear. The summary register follows the last class. A parameter chooses between a combinational and a registered interrupt output.

Top module: `dma_irq_aggr`

## Requirements
- R1: Each class holds N_CH pending bits. Bit n belongs to channel n. A one-cycle pulse on bit n of a class's event input sets that bit, and it reads back on the class's raw slot after the clock edge. Class order is transfer done 0, block done 1, source transaction 2, destination transaction 3, fault 4. Class c occupies addresses 4c (raw), 4c+1 (visible), 4c+2 (enable) and 4c+3 (clear). The summary is at address 20.
- R2: A write to a class's clear slot clears the pending bits of that class where the write data holds a one. Zero bits, and every other class, are left unchanged.
- R3: If an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R4: After reset, all pending bits are zero and every channel is masked (enable bits zero) in all five classes. The summary and the interrupt output are zero.
- R5: An enable-slot write updates enable bit n only when write-data bit N_CH+n is one; the new value is write-data bit n. Enable bits whose write-enable bit is zero keep their value.
- R6: The visible slot of a class reads its pending bits ANDed with its enable bits.
- R7: Summary bit c is one exactly when class c has any visible bit set.
- R8: With the default combinational variant, the interrupt output is one exactly when any class has a visible bit.
- R9: Masking does not stop a pending bit from being recorded. Enabling an already pending channel later raises the interrupt.
- R10: Writes to the raw, visible or summary slots, or to unmapped addresses, change no state. Reads of a clear slot or of an unmapped address return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_xfer_done | input | N_CH | Transfer-done pulses, one per channel |
| ev_block_done | input | N_CH | Block-done pulses |
| ev_src_txn | input | N_CH | Source-transaction pulses |
| ev_dst_txn | input | N_CH | Destination-transaction pulses |
| ev_fault | input | N_CH | Fault pulses |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| pending_classes | output | 5 | One bit per class with visible work |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to create from the ports is an event pulse and a clear write that land on the same channel bit in the same clock cycle, together with a neighbouring bit that is cleared while another is set. The bench drives the event input and the clear write in one cycle and reads the raw slot afterwards. It also checks that a channel whose event arrived while masked only raises the interrupt once its enable bit is written.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

   localparam int NUM_CLASSES     = 5;
   localparam int SLOTS_PER_CLASS = 4;

   typedef enum logic [2:0] {
      CLS_XFER  = 3'd0,
      CLS_BLOCK = 3'd1,
      CLS_SRC   = 3'd2,
      CLS_DST   = 3'd3,
      CLS_FAULT = 3'd4
   } irq_class_e;

   typedef enum logic [1:0] {
      SLOT_RAW   = 2'd0,
      SLOT_VIS   = 2'd1,
      SLOT_MASK  = 2'd2,
      SLOT_CLEAR = 2'd3
   } irq_slot_e;

   // First address after the per-class slots holds the summary word.
   localparam int SUMMARY_ADDR = NUM_CLASSES * SLOTS_PER_CLASS;

endpackage

// File: rtl/dma_irq_class_bank.sv
module dma_irq_class_bank #(
   parameter int N_CH = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] evt,
   input  logic            clr_we,
   input  logic [N_CH-1:0] clr_bits,
   input  logic            mask_we,
   input  logic [N_CH-1:0] mask_wval,
   input  logic [N_CH-1:0] mask_wen,
   output logic [N_CH-1:0] raw,
   output logic [N_CH-1:0] enable,
   output logic [N_CH-1:0] vis,
   output logic            any_vis
);

   generate
      if (N_CH < 1) begin : g_bad_nch
         $error("dma_irq_class_bank: N_CH must be at least 1");
      end
   endgenerate

   logic [N_CH-1:0] clr_eff;
   logic [N_CH-1:0] raw_d;
   logic [N_CH-1:0] enable_d;

   always_comb begin
      clr_eff = clr_we ? clr_bits : '0;
      // event has priority over a coincident clear
      raw_d   = (raw & ~clr_eff) | evt;
   end

   always_comb begin
      enable_d = enable;
      if (mask_we) begin
         for (int i = 0; i < N_CH; i++) begin
            if (mask_wen[i]) enable_d[i] = mask_wval[i];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         raw    <= '0;
         enable <= '0;
      end else begin
         raw    <= raw_d;
         enable <= enable_d;
      end
   end

   assign vis     = raw & enable;
   assign any_vis = |vis;

   genvar gi;
   generate
      for (gi = 0; gi < N_CH; gi++) begin : g_bit_chk
         AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            evt[gi] |=> raw[gi]) else $error("event lost ch %0d", gi); // R3
         AST_CLEAR_HITS: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_we && clr_bits[gi] && !evt[gi]) |=> !raw[gi]) else $error("clear missed ch %0d", gi); // R2
         AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!evt[gi] && !(clr_we && clr_bits[gi])) |=> $stable(raw[gi])) else $error("raw moved ch %0d", gi); // R2
         AST_MASK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
            !(mask_we && mask_wen[gi]) |=> $stable(enable[gi])) else $error("enable moved ch %0d", gi); // R5
         AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_we && mask_wen[gi]) |=> (enable[gi] == $past(mask_wval[gi]))) else $error("enable load ch %0d", gi); // R5
      end
   endgenerate

endmodule

// File: rtl/dma_irq_regif.sv
module dma_irq_regif
   import dma_irq_pkg::*;
#(
   parameter int N_CH   = 8,
   parameter int DATA_W = 16,
   parameter int ADDR_W = 5
) (
   input  logic                        reg_we,
   input  logic [ADDR_W-1:0]           reg_addr,
   input  logic [DATA_W-1:0]           reg_wdata,
   input  logic [NUM_CLASSES*N_CH-1:0] raw_all,
   input  logic [NUM_CLASSES*N_CH-1:0] enable_all,
   input  logic [NUM_CLASSES*N_CH-1:0] vis_all,
   input  logic [NUM_CLASSES-1:0]      summary,
   output logic [NUM_CLASSES-1:0]      clr_we,
   output logic [NUM_CLASSES-1:0]      mask_we,
   output logic [N_CH-1:0]             wr_low,
   output logic [N_CH-1:0]             wr_high,
   output logic [DATA_W-1:0]           reg_rdata
);

   localparam int REG_SPAN = SUMMARY_ADDR + 1;

   generate
      if (DATA_W < 2 * N_CH) begin : g_bad_width
         $error("dma_irq_regif: DATA_W must hold two channel fields");
      end
      if ((1 << ADDR_W) < REG_SPAN) begin : g_bad_addr
         $error("dma_irq_regif: ADDR_W too small for register map");
      end
   endgenerate

   assign wr_low  = reg_wdata[N_CH-1:0];
   assign wr_high = reg_wdata[2*N_CH-1:N_CH];

   generate
      if (DATA_W > 2 * N_CH) begin : g_spare
         logic unused_spare;
         assign unused_spare = |reg_wdata[DATA_W-1:2*N_CH];
      end
   endgenerate

   logic in_class_range;
   logic [ADDR_W-1:0] cls_idx;
   irq_slot_e slot;

   always_comb begin
      in_class_range = (int'(reg_addr) < SUMMARY_ADDR);
      cls_idx        = reg_addr >> 2;
      slot           = irq_slot_e'(reg_addr[1:0]);
   end

   always_comb begin
      clr_we  = '0;
      mask_we = '0;
      for (int c = 0; c < NUM_CLASSES; c++) begin
         if (reg_we && in_class_range && (int'(cls_idx) == c)) begin
            clr_we[c]  = (slot == SLOT_CLEAR);
            mask_we[c] = (slot == SLOT_MASK);
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (int'(reg_addr) == SUMMARY_ADDR) begin
         reg_rdata[NUM_CLASSES-1:0] = summary;
      end else if (in_class_range) begin
         for (int c = 0; c < NUM_CLASSES; c++) begin
            if (int'(cls_idx) == c) begin
               unique case (slot)
                  SLOT_RAW:   reg_rdata[N_CH-1:0] = raw_all[c*N_CH +: N_CH];
                  SLOT_VIS:   reg_rdata[N_CH-1:0] = vis_all[c*N_CH +: N_CH];
                  SLOT_MASK:  reg_rdata[N_CH-1:0] = enable_all[c*N_CH +: N_CH];
                  SLOT_CLEAR: reg_rdata           = '0;
               endcase
            end
         end
      end
   end

   always_comb begin
      AST_ONE_STROBE: assert ($onehot0({clr_we, mask_we})) else $error("two strobes at once"); // R10
   end

endmodule

// File: rtl/dma_irq_aggr.sv
module dma_irq_aggr
   import dma_irq_pkg::*;
#(
   parameter int N_CH        = 8,
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 5,
   parameter bit REG_IRQ_OUT = 1'b0
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [N_CH-1:0]        ev_xfer_done,
   input  logic [N_CH-1:0]        ev_block_done,
   input  logic [N_CH-1:0]        ev_src_txn,
   input  logic [N_CH-1:0]        ev_dst_txn,
   input  logic [N_CH-1:0]        ev_fault,
   input  logic                   reg_we,
   input  logic [ADDR_W-1:0]      reg_addr,
   input  logic [DATA_W-1:0]      reg_wdata,
   output logic [DATA_W-1:0]      reg_rdata,
   output logic [NUM_CLASSES-1:0] pending_classes,
   output logic                   irq
);

   localparam int ALL_W = NUM_CLASSES * N_CH;

   logic [ALL_W-1:0]       ev_all;
   logic [ALL_W-1:0]       raw_all;
   logic [ALL_W-1:0]       enable_all;
   logic [ALL_W-1:0]       vis_all;
   logic [NUM_CLASSES-1:0] any_vis;
   logic [NUM_CLASSES-1:0] clr_we;
   logic [NUM_CLASSES-1:0] mask_we;
   logic [N_CH-1:0]        wr_low;
   logic [N_CH-1:0]        wr_high;

   always_comb begin
      ev_all = '0;
      ev_all[int'(CLS_XFER)  * N_CH +: N_CH] = ev_xfer_done;
      ev_all[int'(CLS_BLOCK) * N_CH +: N_CH] = ev_block_done;
      ev_all[int'(CLS_SRC)   * N_CH +: N_CH] = ev_src_txn;
      ev_all[int'(CLS_DST)   * N_CH +: N_CH] = ev_dst_txn;
      ev_all[int'(CLS_FAULT) * N_CH +: N_CH] = ev_fault;
   end

   genvar gc;
   generate
      for (gc = 0; gc < NUM_CLASSES; gc++) begin : g_class
         dma_irq_class_bank #(.N_CH(N_CH)) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .evt       (ev_all[gc*N_CH +: N_CH]),
            .clr_we    (clr_we[gc]),
            .clr_bits  (wr_low),
            .mask_we   (mask_we[gc]),
            .mask_wval (wr_low),
            .mask_wen  (wr_high),
            .raw       (raw_all[gc*N_CH +: N_CH]),
            .enable    (enable_all[gc*N_CH +: N_CH]),
            .vis       (vis_all[gc*N_CH +: N_CH]),
            .any_vis   (any_vis[gc])
         );
      end
   endgenerate

   dma_irq_regif #(
      .N_CH   (N_CH),
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W)
   ) u_regif (
      .reg_we     (reg_we),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .raw_all    (raw_all),
      .enable_all (enable_all),
      .vis_all    (vis_all),
      .summary    (pending_classes),
      .clr_we     (clr_we),
      .mask_we    (mask_we),
      .wr_low     (wr_low),
      .wr_high    (wr_high),
      .reg_rdata  (reg_rdata)
   );

   assign pending_classes = any_vis;

   generate
      if (REG_IRQ_OUT) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= |vis_all;
         end
         AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
            irq == $past(|pending_classes)) else $error("registered irq mismatch"); // R8
      end else begin : g_irq_comb
         assign irq = |vis_all;
         always_comb begin
            if (rst_n) begin
               AST_IRQ_MATCHES: assert (irq == (|pending_classes)) else $error("irq mismatch"); // R8
            end
         end
      end
   endgenerate

   AST_SUMMARY_VIS: assert property (@(posedge clk) disable iff (!rst_n)
      (pending_classes == '0) |-> ((raw_all & enable_all) == '0)) else $error("summary hides work"); // R7

endmodule

// File: tb/tb_dma_irq_aggr.sv
module tb_dma_irq_aggr;

   localparam int CLK_PERIOD = 10;
   localparam int N_CH   = 8;
   localparam int DATA_W = 16;
   localparam int ADDR_W = 5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N_CH-1:0]   ev_xfer_done = '0, ev_block_done = '0, ev_src_txn = '0;
   logic [N_CH-1:0]   ev_dst_txn = '0, ev_fault = '0;
   logic              reg_we = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [DATA_W-1:0] reg_wdata = '0;
   logic [DATA_W-1:0] reg_rdata;
   logic [4:0]        pending_classes;
   logic              irq;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_irq_aggr #(.N_CH(N_CH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .ev_xfer_done(ev_xfer_done), .ev_block_done(ev_block_done),
      .ev_src_txn(ev_src_txn), .ev_dst_txn(ev_dst_txn), .ev_fault(ev_fault),
      .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pending_classes(pending_classes), .irq(irq)
   );

   // op: 0 write, 1 read-check, 2 event pulse (addr = class index)
   localparam int NV = 24;
   typedef logic [42:0] vec_t; // {op[1:0], addr[4:0], req[3:0], data[15:0], exp[15:0]}
   localparam vec_t VEC [NV] = '{
      {2'd2, 5'd0,  4'd1,  16'h0005, 16'h0000},  // R1 tfr events ch0, ch2
      {2'd1, 5'd0,  4'd1,  16'h0000, 16'h0005},
      {2'd1, 5'd1,  4'd6,  16'h0000, 16'h0000},  // R6 masked
      {2'd1, 5'd20, 4'd7,  16'h0000, 16'h0000},  // R7
      {2'd0, 5'd2,  4'd5,  16'hFF01, 16'h0000},  // R5 unmask ch0
      {2'd1, 5'd2,  4'd5,  16'h0000, 16'h0001},
      {2'd1, 5'd1,  4'd6,  16'h0000, 16'h0001},
      {2'd1, 5'd20, 4'd7,  16'h0000, 16'h0001},
      {2'd0, 5'd2,  4'd5,  16'h0204, 16'h0000},  // R5 only ch1 enabled
      {2'd1, 5'd2,  4'd5,  16'h0000, 16'h0001},
      {2'd2, 5'd4,  4'd1,  16'h0080, 16'h0000},  // R1 fault ch7
      {2'd1, 5'd16, 4'd1,  16'h0000, 16'h0080},
      {2'd0, 5'd18, 4'd5,  16'h8080, 16'h0000},
      {2'd1, 5'd17, 4'd6,  16'h0000, 16'h0080},
      {2'd1, 5'd20, 4'd7,  16'h0000, 16'h0011},
      {2'd0, 5'd3,  4'd2,  16'h0004, 16'h0000},  // R2 clear tfr ch2
      {2'd1, 5'd0,  4'd2,  16'h0000, 16'h0001},
      {2'd1, 5'd16, 4'd2,  16'h0000, 16'h0080},  // R2 other class intact
      {2'd0, 5'd0,  4'd10, 16'h00FF, 16'h0000},  // R10 write to raw slot
      {2'd1, 5'd0,  4'd10, 16'h0000, 16'h0001},
      {2'd1, 5'd21, 4'd10, 16'h0000, 16'h0000},
      {2'd2, 5'd2,  4'd1,  16'h003C, 16'h0000},  // src ch2..5
      {2'd0, 5'd11, 4'd2,  16'h0018, 16'h0000},  // clear ch3, ch4
      {2'd1, 5'd8,  4'd2,  16'h0000, 16'h0024}
   };

   task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic cycle(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                        input int cls, input logic [N_CH-1:0] ev);
      @(negedge clk);
      reg_we = we; reg_addr = a; reg_wdata = d;
      ev_xfer_done  = (cls == 0) ? ev : '0;
      ev_block_done = (cls == 1) ? ev : '0;
      ev_src_txn    = (cls == 2) ? ev : '0;
      ev_dst_txn    = (cls == 3) ? ev : '0;
      ev_fault      = (cls == 4) ? ev : '0;
      @(negedge clk);
      reg_we = 1'b0;
      ev_xfer_done = '0; ev_block_done = '0; ev_src_txn = '0; ev_dst_txn = '0; ev_fault = '0;
   endtask

   task automatic read_chk(input string req, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
      reg_addr = a;
      #1;
      check(req, reg_rdata, exp);
   endtask

   task automatic check_all_zero(input string req);
      for (int a = 0; a <= 21; a++) read_chk(req, ADDR_W'(a), '0);
      check(req, {11'd0, pending_classes}, '0);
      check(req, {15'd0, irq}, '0);
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check_all_zero("R4");            // R4 state while in reset
      rst_n = 1'b1;
      @(negedge clk);
      check_all_zero("R4");

      for (int i = 0; i < NV; i++) begin
         logic [1:0] op;
         logic [4:0] a;
         logic [3:0] rq;
         logic [15:0] d, e;
         {op, a, rq, d, e} = VEC[i];
         case (op)
            2'd0: cycle(1'b1, a, d, -1, '0);
            2'd2: cycle(1'b0, '0, '0, int'(a), d[N_CH-1:0]);
            default: read_chk($sformatf("R%0d", rq), a, e);
         endcase
      end

      // R8: clear all visible work, interrupt drops
      cycle(1'b1, 5'd3, 16'h0001, -1, '0);
      cycle(1'b1, 5'd19, 16'h0080, -1, '0);
      read_chk("R8", 5'd20, 16'h0000);
      check("R8", {15'd0, irq}, 16'h0000);
      // R9: masked source bits still pending, unmask raises irq
      read_chk("R9", 5'd8, 16'h0024);
      cycle(1'b1, 5'd10, 16'h2020, -1, '0);
      check("R9", {15'd0, irq}, 16'h0001);
      read_chk("R7", 5'd20, 16'h0004);

      // R3: event and clear on the same bit in one cycle
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 5'd15; reg_wdata = 16'h0008; ev_dst_txn = 8'h08;
      @(negedge clk);
      reg_we = 1'b0; ev_dst_txn = '0;
      read_chk("R3", 5'd12, 16'h0008);
      // R3: clear ch3 while ch4 fires
      @(negedge clk);
      reg_we = 1'b1; reg_addr = 5'd15; reg_wdata = 16'h0008; ev_dst_txn = 8'h10;
      @(negedge clk);
      reg_we = 1'b0; ev_dst_txn = '0;
      read_chk("R3", 5'd12, 16'h0010);
      // R2: zero write to clear slot changes nothing
      cycle(1'b1, 5'd15, 16'h0000, -1, '0);
      read_chk("R2", 5'd12, 16'h0010);

      // R4: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check_all_zero("R4");
      rst_n = 1'b1;
      @(negedge clk);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule